// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor: seven general registers, two source buses, an arithmetic and logic unit and a write-back path, all steered by a 14-bit control word that arrives every clock. Each cycle carries out exactly one register-transfer micro-operation. Two source selects pick what drives the A and B buses, an opcode picks the ALU function, and a destination select picks which register, if any, captures the result at the next rising edge.

Source select 0 takes the external input bus rather than a register. Destination select 0 writes nothing. These two codes let a sequencer bring data in, move values to the output, or compute without changing any register. The output bus always carries the current ALU result. The sequencer that produces the control words, the instruction fetch and any memory all sit outside this block. There is no state machine: the block holds only the register file, and each control word is decoded fresh every cycle.

Top module: `cw_datapath`

## Requirements
- R1: The control word packs four fields. Bits [13:11] are the A-source select, bits [10:8] are the B-source select, bits [7:5] are the destination select and bits [4:0] are the ALU opcode.
- R2: A source select of 1 to 7 puts general register 1 to 7 on that bus. A source select of 0 puts the external input `data_in` on that bus.
- R3: A destination select of 1 to 7 writes the ALU result into that register at the rising clock edge. A destination select of 0 leaves every register unchanged.
- R4: The ALU opcodes are as follows:
  - 0x00 passes A.
  - 0x01 gives A+1.
  - 0x02 gives A+B.
  - 0x05 gives A−B.
  - 0x06 gives A−1.
  - 0x08 gives A AND B.
  - 0x0A gives A OR B.
  - 0x0C gives A XOR B.
  - 0x0E gives NOT A.
- R5: Opcode 0x10 shifts A right by one bit and opcode 0x18 shifts A left by one bit. Both are logical shifts that bring in a 0.
- R6: Any opcode not listed in R4 or R5 gives a result of zero and drives `illegal_op` high for that cycle. `illegal_op` is low for every listed opcode.
- R7: `data_out` shows the ALU result combinationally in every cycle, whether or not a register is written.
- R8: Reset (`rst_n` low) clears all seven registers to zero.
- R9: A register that is read in the same cycle it is written returns its old value. The new value is seen from the next cycle on.
- R10: All arithmetic wraps modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Micro-operation for this cycle (fields in R1) |
| data_in | input | WIDTH | External input bus, selected by source code 0 |
| data_out | output | WIDTH | ALU result of the current control word |
| illegal_op | output | 1 | High when the opcode is not a defined function |

## Verification
Unlisted opcodes and write-back that is suppressed are hard to reach from the ports. A broken register only becomes visible once a later control word reads it back. For this reason the random stream keeps a cycle-exact model of all seven registers, and every later read compares against that model. About one word in seven uses a raw random opcode, so undefined codes appear many times. Directed sequences cover further cases: a register that is read and written in the same cycle, wrap-around at all-ones and at zero, clearing a register with XOR, and shifting patterns that have both end bits set.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

    localparam int SEL_W    = 3;
    localparam int OPC_W    = 5;
    localparam int CW_W     = 3 * SEL_W + OPC_W;
    localparam int NUM_REGS = (1 << SEL_W) - 1;

    typedef enum logic [OPC_W-1:0] {
        OPC_PASS = 5'b00000,
        OPC_INC  = 5'b00001,
        OPC_ADD  = 5'b00010,
        OPC_SUB  = 5'b00101,
        OPC_DEC  = 5'b00110,
        OPC_AND  = 5'b01000,
        OPC_OR   = 5'b01010,
        OPC_XOR  = 5'b01100,
        OPC_NOT  = 5'b01110,
        OPC_SHR  = 5'b10000,
        OPC_SHL  = 5'b11000
    } alu_opc_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OPC_W-1:0] opc;
    } ctrl_fields_t;

endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile
    import cwdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [WIDTH-1:0]               wr_data,
    output logic [NUM_REGS-1:0][WIDTH-1:0] regs_q
);

    // one storage slot per nonzero destination code
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
        logic hit;
        assign hit = (wr_sel == SEL_W'(gi + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (hit) begin
                regs_q[gi] <= wr_data;
            end
        end

        // R3: a selected slot captures the result presented before the edge
        a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel == SEL_W'(gi + 1)) |=> (regs_q[gi] == $past(wr_data)));

        // R3: an unselected slot (including destination code 0) holds its value
        a_r3_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel != SEL_W'(gi + 1)) |=> $stable(regs_q[gi]));
    end

endmodule

// File: rtl/cwdp_bus_mux.sv
module cwdp_bus_mux
    import cwdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [NUM_REGS-1:0][WIDTH-1:0] regs,
    input  logic [WIDTH-1:0]               ext_in,
    input  logic [SEL_W-1:0]               sel,
    output logic [WIDTH-1:0]               bus
);

    always_comb begin
        bus = ext_in;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                bus = regs[i];
            end
        end
    end

endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu
    import cwdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] result,
    output logic             bad_opc
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        result  = '0;
        bad_opc = 1'b0;
        case (opc)
            OPC_PASS: result = a_in;
            OPC_INC:  result = a_in + ONE;
            OPC_ADD:  result = a_in + b_in;
            OPC_SUB:  result = a_in - b_in;
            OPC_DEC:  result = a_in - ONE;
            OPC_AND:  result = a_in & b_in;
            OPC_OR:   result = a_in | b_in;
            OPC_XOR:  result = a_in ^ b_in;
            OPC_NOT:  result = ~a_in;
            OPC_SHR:  result = {1'b0, a_in[WIDTH-1:1]};
            OPC_SHL:  result = {a_in[WIDTH-2:0], 1'b0};
            default:  bad_opc = 1'b1;
        endcase
    end

    // R6: an undefined opcode never leaks a nonzero value
    a_r6_bad_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opc |-> (result == '0));

    // R4: subtraction undone by adding B back gives A (R10: modulo 2^WIDTH)
    a_r4_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_SUB) |-> (WIDTH'(result + b_in) == a_in));

    // R5: logical right shift brings a zero into the top bit
    a_r5_shr_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_SHR) |-> (result[WIDTH-1] == 1'b0));

    // R5: logical left shift brings a zero into the bottom bit
    a_r5_shl_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_SHL) |-> (result[0] == 1'b0));

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cwdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [13:0]      ctrl_word,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             illegal_op
);

    ctrl_fields_t                   cw;
    logic [NUM_REGS-1:0][WIDTH-1:0] regs;
    logic [WIDTH-1:0]               bus_a;
    logic [WIDTH-1:0]               bus_b;
    logic [WIDTH-1:0]               alu_res;

    // R1: field layout fixed by the packed struct
    assign cw = ctrl_fields_t'(ctrl_word);

    cwdp_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (cw.dst),
        .wr_data (alu_res),
        .regs_q  (regs)
    );

    cwdp_bus_mux #(.WIDTH(WIDTH)) u_mux_a (
        .regs   (regs),
        .ext_in (data_in),
        .sel    (cw.src_a),
        .bus    (bus_a)
    );

    cwdp_bus_mux #(.WIDTH(WIDTH)) u_mux_b (
        .regs   (regs),
        .ext_in (data_in),
        .sel    (cw.src_b),
        .bus    (bus_b)
    );

    cwdp_alu #(.WIDTH(WIDTH)) u_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .opc     (cw.opc),
        .a_in    (bus_a),
        .b_in    (bus_b),
        .result  (alu_res),
        .bad_opc (illegal_op)
    );

    // R7: result bus is never registered
    assign data_out = alu_res;

    // R2: a pass of the input with no write reflects data_in on the output
    a_r2_input_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.src_a == '0 && cw.opc == OPC_PASS) |-> (data_out == data_in));

endmodule

// File: tb/cw_datapath_tb_top.sv
`timescale 1ns/1ps
module cw_datapath_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  ctrl_word = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic         illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model [1:7];

    always #2 clk = ~clk;

    cw_datapath #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_word  (ctrl_word),
        .data_in    (data_in),
        .data_out   (data_out),
        .illegal_op (illegal_op)
    );

    localparam logic [4:0] LEGAL [11] = '{5'h00, 5'h01, 5'h02, 5'h05, 5'h06,
                                          5'h08, 5'h0A, 5'h0C, 5'h0E, 5'h10, 5'h18};

    function automatic logic [W:0] ref_alu(input logic [4:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        case (op)
            5'h00: return {1'b0, a};
            5'h01: return {1'b0, W'(a + 1)};
            5'h02: return {1'b0, W'(a + b)};
            5'h05: return {1'b0, W'(a - b)};
            5'h06: return {1'b0, W'(a - 1)};
            5'h08: return {1'b0, a & b};
            5'h0A: return {1'b0, a | b};
            5'h0C: return {1'b0, a ^ b};
            5'h0E: return {1'b0, ~a};
            5'h10: return {1'b0, a >> 1};
            5'h18: return {1'b0, W'(a << 1)};
            default: return {1'b1, {W{1'b0}}};
        endcase
    endfunction

    function automatic logic [W-1:0] src(input logic [2:0] s, input logic [W-1:0] din);
        return (s == 3'd0) ? din : model[s];
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got flag=%0b out=%02h, expected flag=%0b out=%02h",
                     tag, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    // Drive one control word after the falling edge, check the combinational
    // result before the rising edge, then advance the register model.
    task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                        input logic [4:0] op, input logic [W-1:0] din, input string tag);
        logic [W:0] exp;
        @(negedge clk);
        ctrl_word = {sa, sb, sd, op};
        data_in   = din;
        #1;
        exp = ref_alu(op, src(sa, din), src(sb, din));
        check(tag, {illegal_op, data_out}, exp);
        if (sd != 3'd0) model[sd] = exp[W-1:0];
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 1; i <= 7; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: every register reads zero after reset (pass, no write)
        for (int r = 1; r <= 7; r++) step(3'(r), 3'd0, 3'd0, 5'h00, 8'hA5, "R8");

        // R2: input on both buses, then load registers from input
        step(3'd0, 3'd0, 3'd0, 5'h02, 8'h21, "R2");
        for (int r = 1; r <= 7; r++) step(3'd0, 3'd0, 3'(r), 5'h00, 8'(r * 17), "R2");
        step(3'd0, 3'd5, 3'd0, 5'h02, 8'h01, "R2");

        // R1: packed word 010_011_001_00101 = R1 <- R2 - R3
        @(negedge clk);
        ctrl_word = 14'b010_011_001_00101;
        #1;
        check("R1", {illegal_op, data_out}, {1'b0, W'(model[2] - model[3])});
        model[1] = W'(model[2] - model[3]);
        step(3'd1, 3'd0, 3'd0, 5'h00, 8'h00, "R1");

        // R3: increment R2 with no destination, R2 unchanged afterwards
        step(3'd2, 3'd0, 3'd0, 5'h01, 8'h00, "R3");
        step(3'd2, 3'd0, 3'd0, 5'h00, 8'h00, "R3");
        // R3/R4: XOR of R5 with itself clears it
        step(3'd5, 3'd5, 3'd5, 5'h0C, 8'h00, "R3");
        step(3'd5, 3'd0, 3'd0, 5'h00, 8'h00, "R3");

        // R9: read and write R6 in one cycle, old value seen, new next cycle
        step(3'd6, 3'd0, 3'd6, 5'h01, 8'h00, "R9");
        step(3'd6, 3'd0, 3'd0, 5'h00, 8'h00, "R9");

        // R10: wrap at all-ones and at zero
        step(3'd0, 3'd0, 3'd4, 5'h00, 8'hFF, "R10");
        step(3'd4, 3'd0, 3'd0, 5'h01, 8'h00, "R10");
        step(3'd0, 3'd0, 3'd0, 5'h06, 8'h00, "R10");
        step(3'd0, 3'd0, 3'd0, 5'h05, 8'h00, "R10");

        // R5: shifts with both end bits set
        step(3'd0, 3'd0, 3'd7, 5'h00, 8'h81, "R5");
        step(3'd7, 3'd0, 3'd0, 5'h10, 8'h00, "R5");
        step(3'd7, 3'd0, 3'd0, 5'h18, 8'h00, "R5");

        // R6: undefined opcodes give zero and raise the flag
        step(3'd7, 3'd7, 3'd0, 5'h03, 8'hFF, "R6");
        step(3'd0, 3'd0, 3'd0, 5'h1F, 8'hFF, "R6");
        step(3'd0, 3'd0, 3'd1, 5'h11, 8'h3C, "R6");
        step(3'd1, 3'd0, 3'd0, 5'h00, 8'h00, "R6");

        // R4/R6/R7: random micro-operations against the register model
        for (int n = 0; n < 600; n++) begin
            logic [4:0] op;
            string tag;
            if ($urandom_range(0, 6) == 0) op = 5'($urandom);
            else op = LEGAL[$urandom_range(0, 10)];
            tag = ref_alu(op, '0, '0) >> W ? "R6" : "R4";
            step(3'($urandom), 3'($urandom), 3'($urandom), op, 8'($urandom), tag);
        end

        // R7: final readback of all registers through the output bus
        for (int r = 1; r <= 7; r++) step(3'(r), 3'd0, 3'd0, 5'h00, 8'h00, "R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule